// File: doc/BRIEF.md
# Sparse Row-Allocated Memory

This block presents a wide logical address space while holding storage for only a small pool of physical rows. Each address is split into a row index, taken from the upper bits, and a column index, taken from the lower bits. A translation table holds one entry for each logical row. That entry shows whether the row has been given a physical row yet, and if so which one. No logical row owns storage until it is first written. On that first write, the next unused physical row is taken from the pool. Every later access to that logical row goes to the same physical row.

The write port and the read port are both synchronous and run in the same cycle. Every access does one table lookup and then one access to the row storage. Read results come out one clock after the request. A flag tells the reader when the row was never written. In that case, and for words that were never written inside a row that does have storage, the data returned is a fixed fill pattern. When the pool is used up, writes that would need a fresh row are dropped and a sticky flag records the loss. Writes to rows that already have storage keep working.

Top module: `sparse_row_mem`

## Requirements
- R1: After synchronous reset, no logical row has storage, `pool_full` and `overflow` are 0, and `rd_valid` is 0.
- R2: The row index is `addr[ADDR_W-1:COL_W]` and the column index is `addr[COL_W-1:0]`. Two addresses that differ only in row bits reach different words.
- R3: A write to a row with no storage takes a new physical row, but only while the pool is not full. It then stores the word in that row.
- R4: A write to a row that already has storage stores the word without taking a new row. `pool_full` goes to 1 once exactly `POOL_ROWS` distinct rows have been written.
- R5: A read of a row with no storage returns `FILL` with `rd_unmapped` = 1.
- R6: A read of a written word returns the last data written to that address, with `rd_unmapped` = 0.
- R7: A read of an unwritten word inside a row that has storage returns `FILL` with `rd_unmapped` = 0.
- R8: `rd_valid` is 1 in exactly the cycle after a cycle with `rd_en` = 1.
- R9: When the pool is full, a write that needs a new row is dropped and sets `overflow`. `overflow` and `pool_full` then stay 1 until reset. Writes to rows that already have storage still take effect.
- R10: A read and a write to the same address in the same cycle return the data held before that write. This includes the case where the write gives the row its storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read result present (one cycle after `rd_en`) |
| rd_data | output | DATA_W | Read result |
| rd_unmapped | output | 1 | Read result came from a row never written |
| pool_full | output | 1 | All physical rows taken |
| overflow | output | 1 | Sticky: a write was dropped for lack of rows |

## Verification
Directed scenarios read back from rows that were never written, from written words, and from unwritten words in a row that has storage. These are the three read outcomes, and each one differs in the data returned and in the state of the flag. Addresses that differ only in their row bits, or only in their column bits, show whether the split is correct and whether rows keep apart. Repeated writes into one row, followed by filling the pool, show that rows are taken once per logical row and not once per write. Same-cycle read and write to one address, both on a row that has storage and on a fresh row, check that reads return the data held before the write.

// File: rtl/spm_pkg.sv
package spm_pkg;
  // Outcome of a read once table and storage have both been consulted
  typedef enum logic [1:0] {
    RD_ROW_MISS  = 2'd0,
    RD_WORD_MISS = 2'd1,
    RD_HIT       = 2'd2
  } rd_kind_e;
endpackage

// File: rtl/spm_row_map.sv
module spm_row_map #(
  parameter int ROWS   = 256,
  parameter int ROW_W  = 8,
  parameter int PHYS_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ROW_W-1:0]  wq_row,
  output logic              wq_hit,
  output logic [PHYS_W-1:0] wq_phys,
  input  logic [ROW_W-1:0]  rq_row,
  output logic              rq_hit,
  output logic [PHYS_W-1:0] rq_phys,
  input  logic              set_en,
  input  logic [ROW_W-1:0]  set_row,
  input  logic [PHYS_W-1:0] set_phys
);
  logic              ent_vld  [ROWS];
  logic [PHYS_W-1:0] ent_phys [ROWS];

  // Assigned flags need reset; the row pointers do not
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ROWS; i++) ent_vld[i] <= 1'b0;
    end else if (set_en) begin
      ent_vld[set_row] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) ent_phys[set_row] <= set_phys;
  end

  assign wq_hit  = ent_vld[wq_row];
  assign wq_phys = ent_phys[wq_row];
  assign rq_hit  = ent_vld[rq_row];
  assign rq_phys = ent_phys[rq_row];
endmodule

// File: rtl/spm_alloc.sv
module spm_alloc #(
  parameter int POOL_ROWS = 8,
  parameter int PHYS_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              need,
  output logic              grant,
  output logic [PHYS_W-1:0] grant_phys,
  output logic              full,
  output logic              overflow
);
  localparam int CNT_W = $clog2(POOL_ROWS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(POOL_ROWS);

  logic [CNT_W-1:0] used_q;
  logic             ovf_q;

  assign full       = (used_q == LIMIT);
  assign grant      = need && !full;
  assign grant_phys = used_q[PHYS_W-1:0];
  assign overflow   = ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (grant) used_q <= used_q + 1'b1;
      if (need && full) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/spm_row_store.sv
module spm_row_store #(
  parameter int POOL_ROWS = 8,
  parameter int PHYS_W    = 3,
  parameter int COL_W     = 4,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PHYS_W-1:0] w_phys,
  input  logic [COL_W-1:0]  w_col,
  input  logic [DATA_W-1:0] w_data,
  input  logic              re,
  input  logic [PHYS_W-1:0] r_phys,
  input  logic [COL_W-1:0]  r_col,
  output logic [DATA_W-1:0] r_data,
  output logic              r_written
);
  localparam int IDX_W = PHYS_W + COL_W;
  localparam int WORDS = POOL_ROWS << COL_W;

  logic [DATA_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  written_q;
  logic [IDX_W-1:0]  w_idx, r_idx;

  assign w_idx = {w_phys, w_col};
  assign r_idx = {r_phys, r_col};

  // Plain dual-port array, read-before-write, no reset: maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[w_idx] <= w_data;
    if (re) r_data <= mem[r_idx];
  end

  // One written bit per word, cleared by reset
  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      r_written <= 1'b0;
    end else begin
      if (re) r_written <= written_q[r_idx];
      if (we) written_q[w_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/sparse_row_mem.sv
module sparse_row_mem #(
  parameter int ADDR_W    = 12,
  parameter int COL_W     = 4,
  parameter int DATA_W    = 16,
  parameter int POOL_ROWS = 8,
  parameter logic [DATA_W-1:0] FILL = 16'hA5A5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_unmapped,
  output logic              pool_full,
  output logic              overflow
);
  import spm_pkg::*;

  localparam int ROW_W  = ADDR_W - COL_W;
  localparam int ROWS   = 1 << ROW_W;
  localparam int PHYS_W = (POOL_ROWS > 1) ? $clog2(POOL_ROWS) : 1;

  logic [ROW_W-1:0]  w_row, r_row;
  logic [COL_W-1:0]  w_col, r_col;
  logic              wr_hit, rd_hit;
  logic [PHYS_W-1:0] wr_phys_map, rd_phys_map, alloc_phys, store_phys;
  logic              alloc_need, alloc_grant, store_we, store_re;
  logic [DATA_W-1:0] store_q;
  logic              store_written;
  logic              rd_valid_q, rd_row_hit_q;
  rd_kind_e          rd_kind;

  assign w_row = wr_addr[ADDR_W-1:COL_W];
  assign w_col = wr_addr[COL_W-1:0];
  assign r_row = rd_addr[ADDR_W-1:COL_W];
  assign r_col = rd_addr[COL_W-1:0];

  spm_row_map #(.ROWS(ROWS), .ROW_W(ROW_W), .PHYS_W(PHYS_W)) u_map (
    .clk(clk), .rst(rst),
    .wq_row(w_row), .wq_hit(wr_hit), .wq_phys(wr_phys_map),
    .rq_row(r_row), .rq_hit(rd_hit), .rq_phys(rd_phys_map),
    .set_en(alloc_grant), .set_row(w_row), .set_phys(alloc_phys)
  );

  assign alloc_need = wr_en && !wr_hit;

  spm_alloc #(.POOL_ROWS(POOL_ROWS), .PHYS_W(PHYS_W)) u_alloc (
    .clk(clk), .rst(rst),
    .need(alloc_need), .grant(alloc_grant), .grant_phys(alloc_phys),
    .full(pool_full), .overflow(overflow)
  );

  assign store_we   = wr_en && (wr_hit || alloc_grant);
  assign store_phys = wr_hit ? wr_phys_map : alloc_phys;
  assign store_re   = rd_en && rd_hit;

  spm_row_store #(.POOL_ROWS(POOL_ROWS), .PHYS_W(PHYS_W), .COL_W(COL_W),
                  .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .we(store_we), .w_phys(store_phys), .w_col(w_col), .w_data(wr_data),
    .re(store_re), .r_phys(rd_phys_map), .r_col(r_col),
    .r_data(store_q), .r_written(store_written)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q   <= 1'b0;
      rd_row_hit_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rd_row_hit_q <= rd_hit;
    end
  end

  always_comb begin
    if (!rd_row_hit_q)      rd_kind = RD_ROW_MISS;
    else if (store_written) rd_kind = RD_HIT;
    else                    rd_kind = RD_WORD_MISS;
  end

  assign rd_valid    = rd_valid_q;
  assign rd_data     = (rd_kind == RD_HIT) ? store_q : FILL;
  assign rd_unmapped = rd_valid_q && (rd_kind == RD_ROW_MISS);
endmodule

// File: rtl/sparse_row_mem_chk.sv
module sparse_row_mem_chk #(
  parameter int DATA_W    = 16,
  parameter int POOL_ROWS = 8,
  parameter logic [DATA_W-1:0] FILL = 16'hA5A5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              wr_hit,
  input logic              alloc_grant,
  input logic              rd_valid,
  input logic              rd_unmapped,
  input logic [DATA_W-1:0] rd_data,
  input logic              pool_full,
  input logic              overflow
);
  localparam int GC_W = $clog2(POOL_ROWS + 1) + 1;
  logic [GC_W-1:0] grants;

  always_ff @(posedge clk) begin
    if (rst) grants <= '0;
    else if (alloc_grant) grants <= grants + 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!pool_full && !overflow && !rd_valid));

  p_grant_on_miss_r3: assert property (@(posedge clk) disable iff (rst)
    alloc_grant |-> (wr_en && !wr_hit && !pool_full));

  p_no_alloc_on_hit_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_hit) |-> !alloc_grant);

  p_full_tracks_grants_r4: assert property (@(posedge clk) disable iff (rst)
    pool_full == (grants == GC_W'(POOL_ROWS)));

  p_unmapped_fill_r5: assert property (@(posedge clk) disable iff (rst)
    rd_unmapped |-> (rd_valid && rd_data == FILL));

  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  p_drop_sets_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_hit && pool_full) |=> overflow);

  p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  p_full_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    pool_full |=> pool_full);
endmodule

bind sparse_row_mem sparse_row_mem_chk #(
  .DATA_W(DATA_W), .POOL_ROWS(POOL_ROWS), .FILL(FILL)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
  .wr_hit(wr_hit), .alloc_grant(alloc_grant),
  .rd_valid(rd_valid), .rd_unmapped(rd_unmapped), .rd_data(rd_data),
  .pool_full(pool_full), .overflow(overflow)
);

// File: tb/sim_sparse_row_mem.sv
`timescale 1ns/1ps
module sim_sparse_row_mem;
  localparam int ADDR_W = 12;
  localparam int COL_W  = 4;
  localparam int DATA_W = 16;
  localparam int POOL   = 8;
  localparam logic [DATA_W-1:0] FILL = 16'hA5A5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_valid, rd_unmapped, pool_full, overflow;
  logic [DATA_W-1:0] rd_data;

  int checks = 0;
  int errs   = 0;

  always #4 clk = ~clk;

  sparse_row_mem #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W),
                   .POOL_ROWS(POOL), .FILL(FILL)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_unmapped(rd_unmapped), .pool_full(pool_full), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_expect(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                             input bit unm, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_valid === 1'b1, req, {31'd0, rd_valid}, 32'd1);
    check(rd_data === d, req, {16'd0, rd_data}, {16'd0, d});
    check(rd_unmapped === unm, req, {31'd0, rd_unmapped}, {31'd0, unm});
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(pool_full === 1'b0, "R1", {31'd0, pool_full}, 32'd0);
    check(overflow === 1'b0, "R1", {31'd0, overflow}, 32'd0);
    check(rd_valid === 1'b0, "R1", {31'd0, rd_valid}, 32'd0);
    read_expect(12'h123, FILL, 1'b1, "R5 never-written row");
  endtask

  task automatic t_basic;
    do_write(12'h010, 16'h1111);
    read_expect(12'h010, 16'h1111, 1'b0, "R6 written word");
    read_expect(12'h01F, FILL, 1'b0, "R7 unwritten word in mapped row");
    @(negedge clk);
    check(rd_valid === 1'b0, "R8 no read no valid", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic t_split;
    do_write(12'h020, 16'h2222);
    do_write(12'h110, 16'h3333);
    read_expect(12'h010, 16'h1111, 1'b0, "R2 row bits separate");
    read_expect(12'h110, 16'h3333, 1'b0, "R2 upper row");
    read_expect(12'h020, 16'h2222, 1'b0, "R2 neighbour row");
    read_expect(12'h011, FILL, 1'b0, "R2 column bits separate");
  endtask

  task automatic t_same_row;
    for (int c = 1; c < 8; c++) do_write(12'h010 | c[11:0], 16'h1000 + c[15:0]);
    read_expect(12'h017, 16'h1007, 1'b0, "R4 repeated row writes");
    do_write(12'h017, 16'hBEEF);
    read_expect(12'h017, 16'hBEEF, 1'b0, "R6 overwrite");
  endtask

  task automatic t_rw_same;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 12'h015; wr_data = 16'h6666;
    rd_en = 1'b1; rd_addr = 12'h015;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check(rd_data === 16'h1005, "R10 old data mapped row", {16'd0, rd_data}, 32'h1005);
    read_expect(12'h015, 16'h6666, 1'b0, "R10 new data after");
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 12'h300; wr_data = 16'h0777;
    rd_en = 1'b1; rd_addr = 12'h300;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check(rd_unmapped === 1'b1 && rd_data === FILL, "R10 fresh row reads old",
          {15'd0, rd_unmapped, rd_data}, {15'd0, 1'b1, FILL});
    read_expect(12'h300, 16'h0777, 1'b0, "R3 first write stored");
  endtask

  task automatic t_pool;
    // rows taken so far: 01, 02, 11, 30
    do_write(12'h400, 16'h4000);
    do_write(12'h410, 16'h4100);
    do_write(12'h420, 16'h4200);
    check(pool_full === 1'b0, "R4 seven rows not full", {31'd0, pool_full}, 32'd0);
    do_write(12'h430, 16'h4300);
    check(pool_full === 1'b1, "R4 eight rows full", {31'd0, pool_full}, 32'd1);
    check(overflow === 1'b0, "R9 no drop yet", {31'd0, overflow}, 32'd0);
    do_write(12'h500, 16'h5000);
    check(overflow === 1'b1, "R9 dropped write", {31'd0, overflow}, 32'd1);
    read_expect(12'h500, FILL, 1'b1, "R9 dropped row stays unmapped");
    do_write(12'h012, 16'h0909);
    read_expect(12'h012, 16'h0909, 1'b0, "R9 mapped row still writable");
    read_expect(12'h430, 16'h4300, 1'b0, "R3 last pool row");
    check(overflow === 1'b1 && pool_full === 1'b1, "R9 sticky flags",
          {30'd0, overflow, pool_full}, 32'd3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_split();
    t_same_row();
    t_rw_same();
    t_pool();
    t_reset();
    check(pool_full === 1'b0 && overflow === 1'b0, "R1 reset clears pool",
          {30'd0, overflow, pool_full}, 32'd0);
    read_expect(12'h010, FILL, 1'b1, "R1 rows released by reset");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule